// File: doc/BRIEF.md
# Time-Stamped Event Queue with Back-Pressure Pause

This block turns activity on a group of front-end lines into a stream of time-tagged records. Several data-ready lines, a group of discriminator lines and a sync line are watched. A rising edge on any of them writes one record into an internal queue. Each record holds the value of a free-running 64-bit cycle counter and a bit pattern that shows which lines rose. Three info bits mark sync, pause and resume. A downstream consumer pops records through a first-word-fall-through read port.

When the queue backs up past a high mark, the block raises a pause output to stop the front end. It also writes a pause record, so the time at which collection stopped is kept. While paused, new edges are not stored, and each data-ready edge adds one to a saturating lost-event counter. Once the consumer has drained the queue to a low mark, the block pulses resume for one clock, writes a resume record and releases pause.

Top module: `evq_stamp_fifo`

## Requirements
- R1: A record is written when any of drdy_i, disc_i or sync_i is sampled high at a clock edge after being sampled low at the previous edge (low after reset). A line held high produces exactly one record.
- R2: The record layout is as follows. Bits [63:0] hold the timestamp. The next N_DRDY bits hold the data-ready rise pattern, followed by N_DISC bits for the discriminator rise pattern. The top three bits are, from low to high, sync, pause and resume.
- R3: The timestamp is 0 after reset and increments at every clock edge. A record carries the value the counter held at the edge where the record is written.
- R4: When pause_o is low and the queue holds FULL_MARK (500) or more records at a clock edge, a record with the pause bit set is written at that edge, and pause_o is high from then on.
- R5: When pause_o is high and the queue holds EMPTY_MARK (200) or fewer records, resume_o is high for that single cycle. At the next edge a record with the resume bit set is written and pause_o goes low.
- R6: At an edge where pause_o is high and resume_o is low, no record is written. Instead, miss_cnt_o increases by the number of drdy_i lines that rose.
- R7: miss_cnt_o saturates at all ones. clr_miss_i sets it to 0 at the next edge, and this takes priority over any increment.
- R8: rd_valid_o is high exactly when the queue is not empty, and rd_data_o shows the oldest record. rd_en_i with rd_valid_o high removes that record at the edge. rd_en_i on an empty queue has no effect. The queue never holds more than DEPTH (512) records.
- R9: A pause or resume record and line rises at the same edge form one record with all of those bits set.
- R10: After reset, rd_valid_o, pause_o and resume_o are low and miss_cnt_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drdy_i | input | N_DRDY | Data-ready lines |
| disc_i | input | N_DISC | Discriminator lines |
| sync_i | input | 1 | Sync line |
| rd_en_i | input | 1 | Pop the oldest record |
| clr_miss_i | input | 1 | Synchronous clear of the lost-event counter |
| rd_valid_o | output | 1 | Queue not empty |
| rd_data_o | output | 67+N_DRDY+N_DISC | Oldest record |
| pause_o | output | 1 | Back-pressure to the front end |
| resume_o | output | 1 | One-cycle resume pulse |
| miss_cnt_o | output | MISS_W | Data-ready edges lost while paused |

## Verification
The bench runs four stimulus patterns. First, a single data-ready line is held high for several cycles with reads stopped; this separates edge capture from level capture and pins down the exact timestamp. Next, dense random toggling with frequent reads keeps the queue shallow, which exercises the record layout and pattern merging without any watermark. Third, random toggling with reads stopped fills the queue past the high mark; this shows the pause record, the dropped edges and the counter saturating and clearing. Last, draining under continued activity crosses the low mark, which tells the resume pulse and record apart from ordinary entries. A final drain with no activity ends on an empty queue.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int TS_W   = 64;
  localparam int INFO_W = 3;

  typedef struct packed {
    logic resume;
    logic pause;
    logic sync;
  } evq_info_t;
endpackage

// File: rtl/evq_edge.sv
module evq_edge #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/evq_store.sv
module evq_store #(
  parameter int DW    = 75,
  parameter int DEPTH = 512,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             rd_en_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_valid_o,
  output logic [LVL_W-1:0] level_o
);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] level_q;
  logic             do_wr, do_rd;

  assign do_wr = wr_en_i && (level_q != DEPTH_L);
  assign do_rd = rd_en_i && (level_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_wr) mem[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_wr) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_rd) rd_ptr_q <= rd_ptr_q + 1'b1;
      if (do_wr && !do_rd)      level_q <= level_q + 1'b1;
      else if (do_rd && !do_wr) level_q <= level_q - 1'b1;
    end
  end

  assign rd_data_o  = mem[rd_ptr_q];
  assign rd_valid_o = (level_q != '0);
  assign level_o    = level_q;
endmodule

// File: rtl/evq_throttle.sv
module evq_throttle #(
  parameter int LVL_W      = 10,
  parameter int FULL_MARK  = 500,
  parameter int EMPTY_MARK = 200,
  parameter int N_DRDY     = 4,
  parameter int MISS_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [N_DRDY-1:0] drdy_rise_i,
  input  logic              clr_miss_i,
  output logic              paused_o,
  output logic              pause_evt_o,
  output logic              resume_evt_o,
  output logic              accept_o,
  output logic [MISS_W-1:0] miss_o
);
  localparam logic [LVL_W-1:0] FULL_L  = LVL_W'(FULL_MARK);
  localparam logic [LVL_W-1:0] EMPTY_L = LVL_W'(EMPTY_MARK);

  logic              paused_q;
  logic [MISS_W-1:0] miss_q;
  logic [MISS_W:0]   miss_sum;

  assign pause_evt_o  = !paused_q && (level_i >= FULL_L);
  assign resume_evt_o = paused_q && (level_i <= EMPTY_L);
  assign accept_o     = !paused_q || resume_evt_o;
  assign miss_sum     = {1'b0, miss_q} + (MISS_W+1)'($countones(drdy_rise_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paused_q <= 1'b0;
      miss_q   <= '0;
    end else begin
      if (pause_evt_o)       paused_q <= 1'b1;
      else if (resume_evt_o) paused_q <= 1'b0;
      if (clr_miss_i)         miss_q <= '0;
      else if (!accept_o)     miss_q <= miss_sum[MISS_W] ? '1 : miss_sum[MISS_W-1:0];
    end
  end

  assign paused_o = paused_q;
  assign miss_o   = miss_q;
endmodule

// File: rtl/evq_stamp_fifo.sv
module evq_stamp_fifo
  import evq_pkg::*;
#(
  parameter int N_DRDY     = 4,
  parameter int N_DISC     = 4,
  parameter int DEPTH      = 512,
  parameter int FULL_MARK  = 500,
  parameter int EMPTY_MARK = 200,
  parameter int MISS_W     = 32,
  localparam int N_SRC = N_DRDY + N_DISC + 1,
  localparam int DW    = TS_W + N_DRDY + N_DISC + INFO_W,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_DRDY-1:0] drdy_i,
  input  logic [N_DISC-1:0] disc_i,
  input  logic              sync_i,
  input  logic              rd_en_i,
  input  logic              clr_miss_i,
  output logic              rd_valid_o,
  output logic [DW-1:0]     rd_data_o,
  output logic              pause_o,
  output logic              resume_o,
  output logic [MISS_W-1:0] miss_cnt_o
);
  logic [TS_W-1:0]   ts_q;
  logic [N_SRC-1:0]  rise;
  logic [LVL_W-1:0]  fill_lvl;
  logic              pause_evt, resume_evt, accept, wr_en;
  logic [N_SRC-1:0]  kept;
  evq_info_t         wr_info;
  logic [DW-1:0]     wr_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= '0;
    else         ts_q <= ts_q + 1'b1;
  end

  evq_edge #(.W(N_SRC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({sync_i, disc_i, drdy_i}),
    .rise_o (rise)
  );

  evq_throttle #(
    .LVL_W(LVL_W), .FULL_MARK(FULL_MARK), .EMPTY_MARK(EMPTY_MARK),
    .N_DRDY(N_DRDY), .MISS_W(MISS_W)
  ) u_throttle (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .level_i      (fill_lvl),
    .drdy_rise_i  (rise[N_DRDY-1:0]),
    .clr_miss_i   (clr_miss_i),
    .paused_o     (pause_o),
    .pause_evt_o  (pause_evt),
    .resume_evt_o (resume_evt),
    .accept_o     (accept),
    .miss_o       (miss_cnt_o)
  );

  // edges are dropped while paused; markers merge with same-cycle edges
  assign kept           = accept ? rise : '0;
  assign wr_info.sync   = kept[N_SRC-1];
  assign wr_info.pause  = pause_evt;
  assign wr_info.resume = resume_evt;
  assign wr_en          = (|kept) || pause_evt || resume_evt;
  assign wr_data        = {wr_info, kept[N_SRC-2:0], ts_q};

  evq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_en_i    (rd_en_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .level_o    (fill_lvl)
  );

  assign resume_o = resume_evt;
endmodule

// File: rtl/evq_stamp_fifo_sva.sv
module evq_stamp_fifo_sva #(
  parameter int LVL_W      = 10,
  parameter int DEPTH      = 512,
  parameter int FULL_MARK  = 500,
  parameter int MISS_W     = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [LVL_W-1:0]  level_i,
  input logic              pause_i,
  input logic              resume_i,
  input logic [MISS_W-1:0] miss_i,
  input logic              clr_i,
  input logic              rd_valid_i
);
  localparam logic [LVL_W-1:0] FULL_L  = LVL_W'(FULL_MARK);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (level_i < DEPTH_L));
  assert_empty_invalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == '0) |-> !rd_valid_i);
  assert_pause_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pause_i && level_i >= FULL_L) |=> pause_i);
  assert_pause_mark_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pause_i && level_i >= FULL_L) |-> wr_en_i);
  assert_resume_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_i |=> (!resume_i && !pause_i));
  assert_resume_mark_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_i |-> wr_en_i);
  assert_drop_paused_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_i && !resume_i) |-> !wr_en_i);
  assert_miss_sat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&miss_i) && !clr_i) |=> (&miss_i));
  assert_miss_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (miss_i == '0));
endmodule

bind evq_stamp_fifo evq_stamp_fifo_sva #(
  .LVL_W(LVL_W), .DEPTH(DEPTH), .FULL_MARK(FULL_MARK), .MISS_W(MISS_W)
) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en),
  .level_i    (fill_lvl),
  .pause_i    (pause_o),
  .resume_i   (resume_o),
  .miss_i     (miss_cnt_o),
  .clr_i      (clr_miss_i),
  .rd_valid_i (rd_valid_o)
);

// File: tb/evq_stamp_fifo_tb.sv
module evq_stamp_fifo_tb;
  localparam int NR = 4, ND = 4, DEPTH = 512, FULLM = 500, EMPTYM = 200, MW = 6;
  localparam int DW = 64 + NR + ND + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NR-1:0] drdy = '0;
  logic [ND-1:0] disc = '0;
  logic sync = 1'b0, rd_en = 1'b0, clr = 1'b0;
  logic rd_valid, pause, resume;
  logic [DW-1:0] rd_data;
  logic [MW-1:0] miss;

  int checks = 0, failures = 0;
  bit done = 0, saw_pause = 0, saw_resume = 0;
  longint unsigned edges = 0;

  always #10 clk = ~clk;

  evq_stamp_fifo #(.N_DRDY(NR), .N_DISC(ND), .DEPTH(DEPTH), .FULL_MARK(FULLM),
                   .EMPTY_MARK(EMPTYM), .MISS_W(MW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .drdy_i(drdy), .disc_i(disc), .sync_i(sync),
    .rd_en_i(rd_en), .clr_miss_i(clr), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .pause_o(pause), .resume_o(resume), .miss_cnt_o(miss));

  // reference model built from the requirements
  logic [DW-1:0] mq[$];
  logic [63:0] m_ts;
  logic [NR+ND:0] m_prev;
  bit m_paused;
  int m_miss;

  function automatic int sat_add(int a, int b);
    return (a + b > (1 << MW) - 1) ? (1 << MW) - 1 : a + b;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); m_ts = 0; m_prev = '0; m_paused = 0; m_miss = 0;
    end else begin
      int cnt;
      bit pev, rev, acc;
      logic [NR+ND:0] r;
      cnt = mq.size();
      r   = {sync, disc, drdy} & ~m_prev;
      pev = !m_paused && cnt >= FULLM;
      rev = m_paused && cnt <= EMPTYM;
      acc = !m_paused || rev;
      if (clr) m_miss = 0;
      else if (!acc) m_miss = sat_add(m_miss, $countones(r[NR-1:0]));
      if (rd_en && cnt > 0) void'(mq.pop_front());
      if (((acc && (|r)) || pev || rev) && cnt < DEPTH)
        mq.push_back({rev, pev, (acc ? r : '0), m_ts});
      if (pev) m_paused = 1;
      else if (rev) m_paused = 0;
      m_ts = m_ts + 1;
      m_prev = {sync, disc, drdy};
      edges++;
    end
  end

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(rd_valid == (mq.size() != 0), "R8 rd_valid", DW'(rd_valid), DW'(mq.size() != 0));
    if (mq.size() != 0) chk(rd_data == mq[0], "R1/R2/R3/R9 head record", rd_data, mq[0]);
    chk(pause == m_paused, "R4/R5 pause_o", DW'(pause), DW'(m_paused));
    chk(resume == (m_paused && mq.size() <= EMPTYM), "R5 resume_o", DW'(resume),
        DW'(m_paused && mq.size() <= EMPTYM));
    chk(miss == MW'(m_miss), "R6/R7 miss count", DW'(miss), DW'(m_miss));
    if (pause) saw_pause = 1;
    if (resume) saw_resume = 1;
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
  endtask

  task automatic rand_in(int p_ev, int p_rd);
    if (int'($urandom % 100) < p_ev) drdy = NR'($urandom);
    if ($urandom % 4 == 0) disc = ND'($urandom);
    if ($urandom % 8 == 0) sync = ~sync;
    rd_en = int'($urandom % 100) < p_rd;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    longint unsigned e0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!rd_valid && !pause && !resume && miss == '0, "R10 reset state",
        DW'({rd_valid, pause, resume, miss}), '0);
    rst_n = 1'b1;
    cyc();

    // R1/R3: held level gives one record with the edge-cycle timestamp
    e0 = edges;
    drdy = 4'b0001;
    repeat (5) cyc();
    drdy = '0;
    cyc();
    chk(rd_valid, "R1 one record present", DW'(rd_valid), 1);
    chk(rd_data[63:0] == e0, "R3 timestamp", DW'(rd_data[63:0]), DW'(e0));
    chk(rd_data[DW-1:64] == 11'h001, "R2 pattern bits", DW'(rd_data[DW-1:64]), 1);
    rd_en = 1'b1;
    cyc();
    rd_en = 1'b0;
    cyc();
    chk(!rd_valid, "R1 held level wrote only one record", DW'(rd_valid), 0);
    rd_en = 1'b1;
    cyc();
    chk(!rd_valid, "R8 pop on empty ignored", DW'(rd_valid), 0);

    // shallow queue, dense activity
    for (int i = 0; i < 1500; i++) begin rand_in(70, 60); cyc(); end

    // fill until pause, then keep activity while paused
    for (int i = 0; i < 2000 && !pause; i++) begin rand_in(90, 0); cyc(); end
    chk(saw_pause, "R4 pause reached", DW'(saw_pause), 1);
    for (int i = 0; i < 200; i++) begin rand_in(100, 0); cyc(); end
    chk(miss == '1, "R7 miss counter saturated", DW'(miss), DW'({MW{1'b1}}));
    drdy = '0; rd_en = 1'b0; clr = 1'b1;
    cyc();
    clr = 1'b0;
    chk(miss == '0, "R7 clear", DW'(miss), 0);

    // drain under activity until resume
    for (int i = 0; i < 3000 && !saw_resume; i++) begin
      rand_in(60, 85); clr = ($urandom % 50 == 0); cyc();
    end
    clr = 1'b0;
    chk(saw_resume, "R5 resume reached", DW'(saw_resume), 1);
    cyc();
    chk(!pause && !resume, "R5 pause released", DW'({pause, resume}), 0);

    for (int i = 0; i < 800; i++) begin rand_in(50, 60); cyc(); end

    // final drain, no activity
    drdy = '0; disc = '0; sync = 1'b0; rd_en = 1'b1;
    repeat (DEPTH + 10) cyc();
    chk(!rd_valid, "R8 drained empty", DW'(rd_valid), 0);
    finish_run();
  end
endmodule